// File: doc/BRIEF.md
# Output Voltage Fault Window Monitor

This block supervises a regulator's sensed output voltage, given as a millivolt code, against the millivolt code of the reference DAC. It keeps two fault flags. The first is an undervoltage flag with a set level and a higher clear level. The second is an overvoltage flag. During soft-start its trip level is the larger of a DAC-relative level and a fixed level chosen by the VID mode. The amount the voltage must fall before the overvoltage flag releases depends on which of those two levels caused the trip.

While overvoltage is active, the block forces both lower-gate commands on and holds the third phase's PWM low, so the output is crowbarred through the low-side switches. Protection stops by itself once the voltage falls below the release level, and it repeats for every new event. A single power-good output rises only after a completed soft-start. It falls on any fault, on an external overcurrent indication, on disable, or on a no-CPU VID code.

Top module: `vout_fault_monitor`

## Requirements
- R1: The undervoltage thresholds are registered one cycle from `dac_mv`. The set level is floor(dac_mv*840/1024) and the clear level is floor(dac_mv*870/1024). `uv_flag` sets at a clock edge when `vsense_mv` is strictly below the set level.
- R2: Once set, `uv_flag` clears only when `vsense_mv` is strictly above the clear level. Between the two levels it holds its value. Undervoltage drives no crowbar output.
- R3: While `ss_active` is 1, `ov_flag` sets when `vsense_mv` is strictly above max(dac_mv+150, fixed level). While `ss_active` is 0, it sets when `vsense_mv` is strictly above dac_mv+150.
- R4: The fixed level is 1970 mV when `vid_mode` is 2'b00 (legacy). It is 1670 mV for any other `vid_mode` value.
- R5: The trip source is latched when `ov_flag` sets. The source is fixed only when the fixed level is strictly greater than dac_mv+150 during soft-start. A fixed-sourced trip clears when `vsense_mv` < fixed-100. A DAC-sourced trip clears when `vsense_mv` < dac_mv+100. This holds even if `ss_active` changes during the event.
- R6: While `ov_flag` is 1, `lgate_on` is 2'b11 and `pwm3_low` is 1. Otherwise both are 0.
- R7: `pgood` is 0 whenever `uv_flag`, `ov_flag`, `oc_fault` or `nocpu_code` is 1, or `en` is 0. It returns to 1 on its own once those clear, provided R8 is met.
- R8: Power-good needs a soft-start-done latch. The latch sets when `ss_done` is 1 while `en` is 1 and `nocpu_code` is 0. It is cleared by `en` = 0 or `nocpu_code` = 1. After it clears, `pgood` stays 0 until `ss_done` is seen again.
- R9: With `rst_n` low, `uv_flag`, `ov_flag`, `pgood`, `lgate_on` and `pwm3_low` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en | input | 1 | Controller enable |
| vsense_mv | input | 12 | Sensed differential output voltage, mV |
| dac_mv | input | 12 | Reference DAC voltage, mV |
| ss_active | input | 1 | Soft-start ramp in progress |
| ss_done | input | 1 | Soft-start completed |
| vid_mode | input | 2 | VID table select, 2'b00 = legacy |
| nocpu_code | input | 1 | VID code signals no CPU present |
| oc_fault | input | 1 | Overcurrent indication |
| uv_flag | output | 1 | Undervoltage active |
| ov_flag | output | 1 | Overvoltage active |
| pgood | output | 1 | Power good |
| lgate_on | output | 2 | Force lower gates of phases 1 and 2 on |
| pwm3_low | output | 1 | Force phase 3 PWM low |

## Verification
The bench steps the sensed voltage one millivolt either side of each threshold. A design that uses the wrong inequality or the wrong rounding would trip or release one code early. The bench holds the voltage inside the undervoltage band and inside the overvoltage release gap, which catches a design without hysteresis because it would drop the flag there. One DAC-sourced trip is made with soft-start off. Soft-start is then raised while the voltage sits below the fixed release level, so a design that re-derives the trip source instead of latching it would release early. Other cases check mode selection, which must change the fixed level, and the power-good latch, which must not rise again after a no-CPU code without a new soft-start-done.

// File: rtl/vout_fault_monitor.sv
module vout_fault_monitor #(
  parameter int W          = 12,
  parameter int FRAC_BITS  = 10,
  parameter int UV_SET_NUM = 840,
  parameter int UV_CLR_NUM = 870,
  parameter int OV_OFFSET  = 150,
  parameter int DAC_REL    = 50,
  parameter int FIX_REL    = 100,
  parameter int FIX_LEGACY = 1970,
  parameter int FIX_NEWER  = 1670
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic [W-1:0] vsense_mv,
  input  logic [W-1:0] dac_mv,
  input  logic         ss_active,
  input  logic         ss_done,
  input  logic [1:0]   vid_mode,
  input  logic         nocpu_code,
  input  logic         oc_fault,
  output logic         uv_flag,
  output logic         ov_flag,
  output logic         pgood,
  output logic [1:0]   lgate_on,
  output logic         pwm3_low
);
  localparam int PW = W + FRAC_BITS;
  localparam int XW = W + 2;

  logic [PW-1:0] prod_set, prod_clr;
  logic [W-1:0]  uv_set_q, uv_clr_q;
  logic          uv_q, ov_q, src_fix_q, ss_ok_q;
  logic [XW-1:0] vs_x, dac_ov, fix_lvl, trip_lvl, rel_lvl;
  logic          fix_wins;

  assign prod_set = PW'(dac_mv) * PW'(UV_SET_NUM);
  assign prod_clr = PW'(dac_mv) * PW'(UV_CLR_NUM);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      uv_set_q <= '0;
      uv_clr_q <= '0;
    end else begin
      uv_set_q <= W'(prod_set >> FRAC_BITS);
      uv_clr_q <= W'(prod_clr >> FRAC_BITS);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                          uv_q <= 1'b0;
    else if (!uv_q && vsense_mv < uv_set_q) uv_q <= 1'b1;
    else if (uv_q && vsense_mv > uv_clr_q)  uv_q <= 1'b0;
  end

  assign vs_x     = XW'(vsense_mv);
  assign dac_ov   = XW'(dac_mv) + XW'(OV_OFFSET);
  assign fix_lvl  = (vid_mode == 2'b00) ? XW'(FIX_LEGACY) : XW'(FIX_NEWER);
  assign fix_wins = ss_active && (fix_lvl > dac_ov);
  assign trip_lvl = fix_wins ? fix_lvl : dac_ov;
  assign rel_lvl  = src_fix_q ? (fix_lvl - XW'(FIX_REL)) : (dac_ov - XW'(DAC_REL));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ov_q      <= 1'b0;
      src_fix_q <= 1'b0;
    end else if (!ov_q) begin
      if (vs_x > trip_lvl) begin
        ov_q      <= 1'b1;
        src_fix_q <= fix_wins;
      end
    end else if (vs_x < rel_lvl) begin
      ov_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                ss_ok_q <= 1'b0;
    else if (!en || nocpu_code) ss_ok_q <= 1'b0;
    else if (ss_done)          ss_ok_q <= 1'b1;
  end

  assign uv_flag  = uv_q;
  assign ov_flag  = ov_q;
  assign lgate_on = {2{ov_q}};
  assign pwm3_low = ov_q;
  assign pgood    = ss_ok_q & en & ~nocpu_code & ~oc_fault & ~uv_q & ~ov_q;

  a_r1_uv_set_below: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(uv_q) |-> ($past(vsense_mv) < $past(uv_set_q)));

  a_r2_uv_clear_above: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(uv_q) |-> ($past(vsense_mv) > $past(uv_clr_q)));

  a_r3_ov_trip_above: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ov_q) |-> ($past(vs_x) > $past(trip_lvl)));

  a_r5_ov_release_below: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ov_q) |-> ($past(vs_x) < $past(rel_lvl)));

  a_r5_source_held: assert property (@(posedge clk) disable iff (!rst_n)
    (ov_q && $past(ov_q)) |-> $stable(src_fix_q));

  a_r7_fault_drops_pg: assert property (@(posedge clk) disable iff (!rst_n)
    (uv_q || ov_q) |-> !pgood);

  a_r8_pg_needs_ss: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ss_ok_q) |-> $past(ss_done));
endmodule

// File: tb/vout_fault_monitor_tb.sv
module vout_fault_monitor_tb;
  logic clk = 1'b0;
  logic rst_n, en, ss_active, ss_done, nocpu_code, oc_fault;
  logic [11:0] vsense_mv, dac_mv;
  logic [1:0] vid_mode;
  logic uv_flag, ov_flag, pgood, pwm3_low;
  logic [1:0] lgate_on;
  int n_chk = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  vout_fault_monitor u_dut (
    .clk(clk), .rst_n(rst_n), .en(en), .vsense_mv(vsense_mv), .dac_mv(dac_mv),
    .ss_active(ss_active), .ss_done(ss_done), .vid_mode(vid_mode),
    .nocpu_code(nocpu_code), .oc_fault(oc_fault), .uv_flag(uv_flag),
    .ov_flag(ov_flag), .pgood(pgood), .lgate_on(lgate_on), .pwm3_low(pwm3_low)
  );

  typedef struct packed {
    logic [11:0] vs;
    logic [11:0] dac;
    logic        ss;
    logic [1:0]  mode;
    logic        uv;
    logic        ov;
    logic        pg;
  } vec_t;

  localparam int NV = 22;
  localparam vec_t VEC [NV] = '{
    '{12'd1200, 12'd1200, 1'b0, 2'd1, 1'b0, 1'b0, 1'b1},
    '{12'd990,  12'd1200, 1'b0, 2'd1, 1'b0, 1'b0, 1'b1},
    '{12'd983,  12'd1200, 1'b0, 2'd1, 1'b1, 1'b0, 1'b0},
    '{12'd1000, 12'd1200, 1'b0, 2'd1, 1'b1, 1'b0, 1'b0},
    '{12'd1019, 12'd1200, 1'b0, 2'd1, 1'b1, 1'b0, 1'b0},
    '{12'd1020, 12'd1200, 1'b0, 2'd1, 1'b0, 1'b0, 1'b1},
    '{12'd1350, 12'd1200, 1'b0, 2'd1, 1'b0, 1'b0, 1'b1},
    '{12'd1351, 12'd1200, 1'b0, 2'd1, 1'b0, 1'b1, 1'b0},
    '{12'd1300, 12'd1200, 1'b0, 2'd1, 1'b0, 1'b1, 1'b0},
    '{12'd1299, 12'd1200, 1'b0, 2'd1, 1'b0, 1'b0, 1'b1},
    '{12'd1600, 12'd800,  1'b1, 2'd1, 1'b0, 1'b0, 1'b1},
    '{12'd1671, 12'd800,  1'b1, 2'd1, 1'b0, 1'b1, 1'b0},
    '{12'd1570, 12'd800,  1'b1, 2'd1, 1'b0, 1'b1, 1'b0},
    '{12'd1569, 12'd800,  1'b1, 2'd1, 1'b0, 1'b0, 1'b1},
    '{12'd1900, 12'd800,  1'b1, 2'd0, 1'b0, 1'b0, 1'b1},
    '{12'd1971, 12'd800,  1'b1, 2'd0, 1'b0, 1'b1, 1'b0},
    '{12'd1870, 12'd800,  1'b1, 2'd0, 1'b0, 1'b1, 1'b0},
    '{12'd1869, 12'd800,  1'b1, 2'd0, 1'b0, 1'b0, 1'b1},
    '{12'd1700, 12'd1900, 1'b1, 2'd1, 1'b0, 1'b0, 1'b1},
    '{12'd2051, 12'd1900, 1'b1, 2'd1, 1'b0, 1'b1, 1'b0},
    '{12'd2000, 12'd1900, 1'b1, 2'd1, 1'b0, 1'b1, 1'b0},
    '{12'd1999, 12'd1900, 1'b1, 2'd1, 1'b0, 1'b0, 1'b1}
  };

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic settle(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    #1500000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; en = 1'b1; ss_active = 1'b0; ss_done = 1'b0;
    nocpu_code = 1'b0; oc_fault = 1'b0; vid_mode = 2'd1;
    vsense_mv = 12'd1200; dac_mv = 12'd1200;
    settle(3);
    // R9 reset state
    chk("R9 uv", uv_flag, 0);
    chk("R9 ov", ov_flag, 0);
    chk("R9 pgood", pgood, 0);
    chk("R9 lgate", lgate_on, 0);
    chk("R9 pwm3", pwm3_low, 0);
    rst_n = 1'b1;
    settle(3);
    chk("R8 pg before ss_done", pgood, 0);
    ss_done = 1'b1;
    settle(1);
    ss_done = 1'b0;
    settle(2);
    chk("R8 pg after ss_done", pgood, 1);

    // R1 R2 R3 R4 R5 R6 R7 table walk
    for (int i = 0; i < NV; i++) begin
      vsense_mv = VEC[i].vs; dac_mv = VEC[i].dac;
      ss_active = VEC[i].ss; vid_mode = VEC[i].mode;
      settle(3);
      chk($sformatf("R1/R2 uv vec%0d", i), uv_flag, VEC[i].uv);
      chk($sformatf("R3/R4/R5 ov vec%0d", i), ov_flag, VEC[i].ov);
      chk($sformatf("R7 pgood vec%0d", i), pgood, VEC[i].pg);
      chk($sformatf("R6 lgate vec%0d", i), lgate_on, VEC[i].ov ? 3 : 0);
      chk($sformatf("R6 pwm3 vec%0d", i), pwm3_low, VEC[i].ov);
    end

    // R5 latched source: DAC trip, then soft-start raises fixed level
    dac_mv = 12'd800; vid_mode = 2'd1; ss_active = 1'b0; vsense_mv = 12'd951;
    settle(3);
    chk("R5 dac trip", ov_flag, 1);
    ss_active = 1'b1; vsense_mv = 12'd1000;
    settle(3);
    chk("R5 source kept dac", ov_flag, 1);
    vsense_mv = 12'd899;
    settle(3);
    chk("R5 dac release", ov_flag, 0);
    ss_active = 1'b0; vsense_mv = 12'd800;
    settle(3);
    chk("R7 pg restored", pgood, 1);

    // R7 overcurrent
    oc_fault = 1'b1;
    settle(1);
    chk("R7 oc pg low", pgood, 0);
    oc_fault = 1'b0;
    settle(1);
    chk("R7 oc pg back", pgood, 1);

    // R8 no-CPU code clears latch
    nocpu_code = 1'b1;
    settle(2);
    chk("R7 nocpu pg low", pgood, 0);
    nocpu_code = 1'b0;
    settle(3);
    chk("R8 pg waits ss_done", pgood, 0);
    ss_done = 1'b1;
    settle(1);
    ss_done = 1'b0;
    settle(1);
    chk("R8 pg after new ss_done", pgood, 1);

    // R7 R8 disable
    en = 1'b0;
    settle(2);
    chk("R7 disable pg low", pgood, 0);
    en = 1'b1;
    settle(3);
    chk("R8 enable needs ss_done", pgood, 0);
    ss_done = 1'b1; en = 1'b0;
    settle(2);
    chk("R8 ss_done ignored while disabled", pgood, 0);
    en = 1'b1;
    settle(2);
    chk("R8 ss_done with en", pgood, 1);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule